// File: doc/BRIEF.md
# I2C Master FIFO and Status Unit

This unit holds the two queues between the processor and the command sequencer of an I2C master. The processor queues 10-bit command words: a data byte plus a start-request flag and a stop-request flag. It drains received bytes through a small register bus. The sequencer pops command words and pushes received bytes on dedicated ports.

Software sees occupancy counts that read one less than the number of stored entries, with an empty queue also reading zero. It also sees a status byte with empty, full and bus-busy flags, a control byte and a programmable receive threshold. Three level event outputs feed a separate interrupt block: transmit empty, transmit at or below half, and receive threshold reached. They are derived from the occupancy without a register, so the interrupt block can capture their edges.

A flush bit in the control byte holds the transmit queue empty while it is set.

Top module: `i2c_fifo_stat`

## Requirements
- R1: After reset the control byte reads 0x00, the receive threshold reads 15, and both queues are empty with both occupancy registers reading 0.
- R2: A register write to address 2 queues `reg_wdata[9:0]`, where bits 7:0 are data, bit 8 requests a start and bit 9 requests a stop. `tx_word` presents the oldest word while `tx_avail` is high. A `tx_pop` pulse removes it, words leave in the order written, and a `tx_pop` while the queue is empty has no effect.
- R3: The transmit occupancy register at address 4 reads the stored count minus one when the queue is not empty, and 0 when it is empty.
- R4: A write to address 2 while 16 words are held is discarded, and the queued contents are unchanged.
- R5: `rx_push` stores `rx_byte`. A read of address 3 returns the oldest byte and removes it. The receive occupancy register at address 5 reads the count minus one, or 0 when the queue is empty.
- R6: A read of address 3 while the receive queue is empty returns the byte most recently removed and leaves the queue empty. A push while 16 bytes are held is discarded.
- R7: The status byte at address 1 has these bits: bit 2 = `bus_busy`, bit 4 = transmit full, bit 5 = receive full, bit 6 = receive empty, bit 7 = transmit empty. All other bits read 0.
- R8: The control byte at address 0 reads back bits 1:0. Bit 0 drives `dev_en`. While bit 1 is set, the transmit queue is emptied from the next cycle on and writes to address 2 are discarded.
- R9: `ev_tx_empty` is high exactly when the transmit queue holds no words. `ev_tx_half` is high when it holds 8 words or fewer.
- R10: The threshold register at address 6 holds a 4-bit zero-based value T that reads back. `ev_rx_thr` is high when the receive queue holds T+1 bytes or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the access |
| bus_busy | input | 1 | Bus busy flag from the bit engine |
| dev_en | output | 1 | Device enable from control bit 0 |
| tx_pop | input | 1 | Sequencer removes the oldest command word |
| tx_word | output | 10 | Oldest command word |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Sequencer stores a received byte |
| rx_byte | input | 8 | Received byte |
| ev_tx_empty | output | 1 | Transmit queue empty event |
| ev_tx_half | output | 1 | Transmit queue at or below half event |
| ev_rx_thr | output | 1 | Receive threshold reached event |

## Verification
The bound checker watches invariants on every cycle:
- a full transmit queue never grows;
- a pop with no write and no flush takes exactly one word away;
- a set flush bit leaves the queue empty on the next cycle;
- an empty receive queue stays empty across a data read;
- a full receive queue always raises the threshold event.

Other behaviours can only be shown by the bench's scenarios: word and byte ordering through the queues, the off-by-one occupancy readback, the half-empty boundary between 9 and 8 words, the value returned by an empty read, and that dropped entries never reappear.

// File: rtl/i2cfs_pkg.sv
package i2cfs_pkg;
  // Register addresses
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_STAT  = 3'd1;
  localparam logic [2:0] RA_TXD   = 3'd2;
  localparam logic [2:0] RA_RXD   = 3'd3;
  localparam logic [2:0] RA_TXOCC = 3'd4;
  localparam logic [2:0] RA_RXOCC = 3'd5;
  localparam logic [2:0] RA_RXTHR = 3'd6;

  // Status bit positions
  localparam int STB_BUSY    = 2;
  localparam int STB_TXFULL  = 4;
  localparam int STB_RXFULL  = 5;
  localparam int STB_RXEMPTY = 6;
  localparam int STB_TXEMPTY = 7;

  // Control bit positions
  localparam int CTB_EN    = 0;
  localparam int CTB_FLUSH = 1;

  localparam int CMD_W  = 10;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cfs_fifo.sv
// Synchronous queue; DEPTH must be a power of two.
module i2cfs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign dout    = mem[rp_q];
  assign cnt     = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = wp_q + AW'(1);
      if (do_pop)  rp_d = rp_q + AW'(1);
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; written only under its enable.
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/i2cfs_regs.sv
module i2cfs_regs
  import i2cfs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [CMD_W-1:0]  reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bus_busy,
  input  logic [CW-1:0]     tx_cnt,
  input  logic [CW-1:0]     rx_cnt,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic              rx_empty,
  input  logic [BYTE_W-1:0] rx_head,
  output logic              dev_en,
  output logic              tx_flush,
  output logic [AW-1:0]     rx_thr,
  output logic              tx_push,
  output logic              rx_pop
);
  logic [1:0]        ctrl_q, ctrl_d;
  logic [AW-1:0]     thr_q, thr_d;
  logic [BYTE_W-1:0] last_q, last_d;
  logic [7:0]        stat;

  function automatic logic [7:0] zero_based(input logic [CW-1:0] c);
    logic [CW-1:0] m;
    m = (c == '0) ? '0 : c - CW'(1);
    return 8'(m[AW-1:0]);
  endfunction

  assign tx_push  = reg_wr & (reg_addr == RA_TXD);
  assign rx_pop   = reg_rd & (reg_addr == RA_RXD);
  assign dev_en   = ctrl_q[CTB_EN];
  assign tx_flush = ctrl_q[CTB_FLUSH];
  assign rx_thr   = thr_q;

  always_comb begin
    stat              = '0;
    stat[STB_BUSY]    = bus_busy;
    stat[STB_TXFULL]  = tx_full;
    stat[STB_RXFULL]  = rx_full;
    stat[STB_RXEMPTY] = rx_empty;
    stat[STB_TXEMPTY] = tx_empty;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    thr_d  = thr_q;
    last_d = last_q;
    if (reg_wr && reg_addr == RA_CTRL)  ctrl_d = reg_wdata[1:0];
    if (reg_wr && reg_addr == RA_RXTHR) thr_d  = reg_wdata[AW-1:0];
    if (rx_pop && !rx_empty)            last_d = rx_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      thr_q  <= AW'(DEPTH - 1);
      last_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      thr_q  <= thr_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = {6'b0, ctrl_q};
      RA_STAT:  reg_rdata = stat;
      RA_RXD:   reg_rdata = rx_empty ? last_q : rx_head;
      RA_TXOCC: reg_rdata = zero_based(tx_cnt);
      RA_RXOCC: reg_rdata = zero_based(rx_cnt);
      RA_RXTHR: reg_rdata = 8'(thr_q);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cfs_events.sv
module i2cfs_events #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  input  logic [AW-1:0] rx_thr,
  output logic          ev_tx_empty,
  output logic          ev_tx_half,
  output logic          ev_rx_thr
);
  assign ev_tx_empty = (tx_cnt == '0);
  assign ev_tx_half  = (tx_cnt <= CW'(HALF));
  assign ev_rx_thr   = (rx_cnt > CW'(rx_thr));
endmodule

// File: rtl/i2c_fifo_stat.sv
module i2c_fifo_stat
  import i2cfs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [CMD_W-1:0]  reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bus_busy,
  output logic              dev_en,
  input  logic              tx_pop,
  output logic [CMD_W-1:0]  tx_word,
  output logic              tx_avail,
  input  logic              rx_push,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              ev_tx_empty,
  output logic              ev_tx_half,
  output logic              ev_rx_thr
);
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [BYTE_W-1:0] rx_head;
  logic              tx_flush, tx_push, rx_pop;
  logic [AW-1:0]     rx_thr;

  assign tx_avail = ~tx_empty;

  i2cfs_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_flush),
    .push(tx_push), .din(reg_wdata), .pop(tx_pop),
    .dout(tx_word), .cnt(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  i2cfs_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(1'b0),
    .push(rx_push), .din(rx_byte), .pop(rx_pop),
    .dout(rx_head), .cnt(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  i2cfs_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_busy(bus_busy),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_head(rx_head),
    .dev_en(dev_en), .tx_flush(tx_flush), .rx_thr(rx_thr),
    .tx_push(tx_push), .rx_pop(rx_pop)
  );

  i2cfs_events #(.DEPTH(DEPTH)) u_ev (
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_thr(rx_thr),
    .ev_tx_empty(ev_tx_empty), .ev_tx_half(ev_tx_half),
    .ev_rx_thr(ev_rx_thr)
  );
endmodule

// File: rtl/i2cfs_chk.sv
module i2cfs_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic          tx_pop,
  input logic          tx_avail,
  input logic          rx_push,
  input logic          ev_tx_empty,
  input logic          ev_rx_thr,
  input logic          tx_flush,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  // R4
  tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(DEPTH) && reg_wr && reg_addr == 3'd2 && !tx_pop && !tx_flush)
    |=> (tx_cnt == CW'(DEPTH)));

  // R4
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  // R2
  tx_pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_avail && tx_pop && !(reg_wr && reg_addr == 3'd2) && !tx_flush)
    |=> (tx_cnt == $past(tx_cnt) - CW'(1)));

  // R8
  tx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_cnt == '0));

  // R6
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && reg_rd && reg_addr == 3'd3 && !rx_push) |=> (rx_cnt == '0));

  // R10
  rx_full_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CW'(DEPTH)) |-> ev_rx_thr);

  // R9
  tx_empty_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_empty |-> !tx_avail);
endmodule

bind i2c_fifo_stat i2cfs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .tx_pop(tx_pop), .tx_avail(tx_avail),
  .rx_push(rx_push), .ev_tx_empty(ev_tx_empty), .ev_rx_thr(ev_rx_thr),
  .tx_flush(tx_flush), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/sim_i2c_fifo_stat.sv
module sim_i2c_fifo_stat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [9:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       bus_busy = 1'b0;
  logic       dev_en;
  logic       tx_pop = 1'b0;
  logic [9:0] tx_word;
  logic       tx_avail;
  logic       rx_push = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       ev_tx_empty, ev_tx_half, ev_rx_thr;

  int n_tests = 0;
  int n_fail  = 0;
  logic [9:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] last_m = 8'h00;
  bit flush_m = 0;

  always #10 clk = ~clk;

  i2c_fifo_stat u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [9:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #8 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // Driver: queues the expected word when the model says it is accepted.
  task automatic push_tx(input logic [9:0] w);
    wr(3'd2, w);
    if (!flush_m && txq.size() < 16) txq.push_back(w);
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_push = 1'b1; rx_byte = b;
    @(negedge clk); rx_push = 1'b0;
    if (rxq.size() < 16) rxq.push_back(b);
  endtask

  task automatic read_rx(input string req);
    logic [7:0] v, e;
    if (rxq.size() > 0) begin e = rxq.pop_front(); last_m = e; end
    else e = last_m;
    rd(3'd3, v);
    chk(req, v, e);
  endtask

  task automatic settle();
    @(negedge clk); #8;
  endtask

  // Monitor: compares every popped transmit word against the scoreboard.
  always begin
    @(negedge clk); #8;
    if (tx_pop && tx_avail) begin
      if (txq.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R2: actual 0x%0h expected none", tx_word);
      end else begin
        chk("R2 tx word order", tx_word, txq.pop_front());
      end
    end
  end

  initial begin
    #(20 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1, R7, R9 reset state
    settle();
    chk("R1 dev_en", dev_en, 0);
    chk("R9 ev_tx_empty reset", ev_tx_empty, 1);
    chk("R9 ev_tx_half reset", ev_tx_half, 1);
    chk("R10 ev_rx_thr reset", ev_rx_thr, 0);
    rd_chk("R1 ctrl", 3'd0, 8'h00);
    rd_chk("R1 threshold", 3'd6, 15);
    rd_chk("R1 tx occ", 3'd4, 0);
    rd_chk("R1 rx occ", 3'd5, 0);
    rd_chk("R7 status reset", 3'd1, 8'hC0);

    // R8 enable
    wr(3'd0, 10'h001);
    settle();
    chk("R8 dev_en", dev_en, 1);
    rd_chk("R8 ctrl readback", 3'd0, 8'h01);

    // R2, R3 small transfer with start/stop flags
    push_tx(10'h1A5);
    push_tx(10'h012);
    push_tx(10'h2FF);
    rd_chk("R3 tx occ 3 words", 3'd4, 2);
    settle();
    chk("R9 ev_tx_empty busy", ev_tx_empty, 0);
    chk("R9 ev_tx_half 3", ev_tx_half, 1);
    for (int i = 0; i < 3; i++) pop_tx();
    rd_chk("R3 tx occ after drain", 3'd4, 0);
    // R2 pop on empty has no effect
    pop_tx();
    settle();
    chk("R2 tx_avail empty", tx_avail, 0);
    rd_chk("R2 occ after empty pop", 3'd4, 0);
    push_tx(10'h0C3);
    rd_chk("R3 tx occ 1 word", 3'd4, 0);
    settle();
    chk("R2 tx_avail one", tx_avail, 1);
    pop_tx();

    // R4 full and dropped write
    for (int i = 0; i < 16; i++) push_tx(10'((i * 37 + 5) & 10'h3FF));
    rd_chk("R3 tx occ full", 3'd4, 15);
    rd_chk("R7 status tx full", 3'd1, 8'h50);
    settle();
    chk("R9 ev_tx_half full", ev_tx_half, 0);
    push_tx(10'h3AA);
    rd_chk("R4 occ after dropped", 3'd4, 15);
    for (int i = 0; i < 7; i++) pop_tx();
    settle();
    chk("R9 ev_tx_half at 9", ev_tx_half, 0);
    pop_tx();
    settle();
    chk("R9 ev_tx_half at 8", ev_tx_half, 1);
    for (int i = 0; i < 8; i++) pop_tx();
    chk("R4 scoreboard drained", txq.size(), 0);

    // R8 flush
    for (int i = 0; i < 5; i++) push_tx(10'(10'h100 + i));
    wr(3'd0, 10'h003);
    flush_m = 1; txq.delete();
    rd_chk("R8 flush occ", 3'd4, 0);
    rd_chk("R8 flush status", 3'd1, 8'hC0);
    push_tx(10'h055);
    rd_chk("R8 push during flush", 3'd4, 0);
    settle();
    chk("R8 tx_avail flushed", tx_avail, 0);
    wr(3'd0, 10'h001);
    flush_m = 0;
    rd_chk("R8 ctrl after flush", 3'd0, 8'h01);
    push_tx(10'h277);
    pop_tx();

    // R7 bus busy
    bus_busy = 1'b1;
    rd_chk("R7 status busy", 3'd1, 8'hC4);
    bus_busy = 1'b0;

    // R5, R10 receive path and threshold
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33); push_rx(8'h44);
    rd_chk("R5 rx occ 4", 3'd5, 3);
    wr(3'd6, 10'd3);
    rd_chk("R10 threshold readback", 3'd6, 3);
    settle();
    chk("R10 ev at T+1", ev_rx_thr, 1);
    wr(3'd6, 10'd4);
    settle();
    chk("R10 ev below", ev_rx_thr, 0);
    push_rx(8'h55);
    settle();
    chk("R10 ev reached", ev_rx_thr, 1);
    for (int i = 0; i < 4; i++) read_rx("R5 rx byte order");
    rd_chk("R5 rx occ 1", 3'd5, 0);
    read_rx("R5 rx last byte");
    rd_chk("R7 rx empty status", 3'd1, 8'hC0);
    // R6 empty read returns last byte
    read_rx("R6 empty read");
    rd_chk("R6 occ after empty read", 3'd5, 0);

    // R6, R10 full receive queue
    wr(3'd6, 10'd15);
    for (int i = 0; i < 15; i++) push_rx(8'(8'hA0 + i * 3));
    settle();
    chk("R10 ev at 15 of T=15", ev_rx_thr, 0);
    push_rx(8'h7E);
    settle();
    chk("R10 ev at 16", ev_rx_thr, 1);
    rd_chk("R7 rx full status", 3'd1, 8'hA0);
    push_rx(8'hEE);
    rd_chk("R6 occ after dropped", 3'd5, 15);
    for (int i = 0; i < 16; i++) read_rx("R6 rx order after drop");
    read_rx("R6 empty read after full");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule